// File: doc/BRIEF.md
# Privileged Control Register Access Arbiter

This block holds two 64-bit control registers. One is the hypervisor view and the other is the kernel view. It decides the outcome of every system-register read or write that names either register. Each request carries:

- the current privilege level (0 to 3),
- a read/write flag,
- a register-name select,
- write data,
- a set of configuration qualifiers.

From these the block chooses one of six outcomes. The access may be undefined. It may trap to level 2 or to level 3, which reports syndrome class 0x18. It may be redirected to a memory slot at offset 0x8E8. Otherwise it reaches the hypervisor-view register or the kernel-view register.

The checks are prioritised and depend on privilege. Level 0 is always refused. At level 1 the hypervisor name traps or is undefined, decided by the nested-virtualisation mode. At level 1 the kernel name walks an ordered chain of checks before it reaches its register or the memory redirect. At level 2 the level-3 enable gate is checked first, and in host mode the kernel name aliases onto the hypervisor register. Level 3 reaches both registers with no checks.

The control is a two-state machine:

- `ST_IDLE` means no response is pending.
- `ST_RESP` means a response is valid this cycle.
- The transition "accept" (`ST_IDLE` to `ST_RESP`) and "chain" (`ST_RESP` to `ST_RESP`) are both taken when a request strobe is seen.
- The transition "retire" (`ST_RESP` to `ST_IDLE`) is taken when there is no strobe.
- The transition "wait" (`ST_IDLE` to `ST_IDLE`) holds the machine when idle.

Top module: `pcr_access_arbiter`

## Requirements
- R1: After reset both registers read as zero and `rsp_valid` is 0.
- R2: Any access at level 0 (`req_el`=0) gives `rsp_undef`=1 and neither trap.
- R3: At level 1 the hypervisor name (`req_sel`=0) traps to level 2 when `cfg_nv[0]`=1, and is undefined otherwise.
- R4: At level 2, when `cfg_l3_present`=1 and `cfg_l3_en`=0, either name is undefined if `cfg_undef_prio`=1. Otherwise it is undefined if `cfg_undef_sel`=1, and it traps to level 3 if `cfg_undef_sel`=0.
- R5: `rsp_syn_class` is 0x18 whenever a trap is reported and 0 otherwise.
- R6: At level 1 the kernel name (`req_sel`=1) is checked in this priority order:
  - undefined, by the level-3 gate with `cfg_undef_prio`;
  - the fine-grained trap to level 2;
  - the trap to level 2 when `cfg_l2_en`=1 and `cfg_l2_pm_en`=0;
  - the level-3 gate, undefined or trap to level 3 as `cfg_undef_sel` chooses.
- R7: The fine-grained trap needs `cfg_l2_en`=1 and `cfg_fg_impl`=1. It then applies when (`cfg_l3_present`=1 and `cfg_l3_fg_en`=0), or when the direction bit is 0. A read uses `cfg_fg_rd_ok` and a write uses `cfg_fg_wr_ok`.
- R8: At level 1, a kernel-name access with `cfg_nv`=3'b111 that hits no trap is redirected: `rsp_mem_redir`=1, `rsp_mem_ofs`=0x8E8, `rsp_mem_wr` equals the write flag, `rsp_mem_wdata` carries the data, and the register is untouched.
- R9: At level 2 with the gate open, the kernel name reaches the hypervisor register when `cfg_host`=1, and reaches the kernel register otherwise.
- R10: At level 3 both names reach their own registers, whatever the configuration.
- R11: Each strobe yields exactly one response, with `rsp_valid` high in the cycle after the strobe. At most one of undef, trap-to-2, trap-to-3 and redirect is set.
- R12: A write that is undefined, trapped or redirected leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_el | input | 2 | Current privilege level |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | Register name: 0 hypervisor view, 1 kernel view |
| req_wdata | input | DATA_W | Write data |
| cfg_nv | input | 3 | Nested-virtualisation mode |
| cfg_host | input | 1 | Host mode at level 2 |
| cfg_l2_en | input | 1 | Level 2 enabled in the current state |
| cfg_l3_present | input | 1 | Level 3 implemented |
| cfg_l3_en | input | 1 | Level-3 enable for these registers |
| cfg_l2_pm_en | input | 1 | Level-2 enable for level-1 access |
| cfg_fg_impl | input | 1 | Fine-grained traps implemented |
| cfg_l3_fg_en | input | 1 | Level-3 enable of fine-grained controls |
| cfg_fg_rd_ok | input | 1 | Fine-grained read permit (0 traps) |
| cfg_fg_wr_ok | input | 1 | Fine-grained write permit (0 traps) |
| cfg_undef_prio | input | 1 | Undefined takes priority at the level-3 gate |
| cfg_undef_sel | input | 1 | At the level-3 gate: 1 undefined, 0 trap to level 3 |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | DATA_W | Read data (0 unless a register read) |
| rsp_undef | output | 1 | Access undefined |
| rsp_trap_l2 | output | 1 | Trap to level 2 |
| rsp_trap_l3 | output | 1 | Trap to level 3 |
| rsp_syn_class | output | EC_W | Syndrome class of a trap |
| rsp_mem_redir | output | 1 | Redirect to memory request |
| rsp_mem_wr | output | 1 | Redirected access is a write |
| rsp_mem_ofs | output | OFS_W | Memory offset of the redirect |
| rsp_mem_wdata | output | DATA_W | Data of a redirected write |

## Verification
The bench builds the block with its default parameters:

- 64-bit registers;
- a 12-bit offset holding 0x8E8;
- a 6-bit syndrome class of 0x18.

With these defaults, full-width patterns with distinct upper and lower halves can be written and read back. This shows any aliasing between the two registers or a lost half-word. Every level-1 kernel-name qualifier can be toggled one at a time, so each rung of the priority chain is reached and shown to shadow the rungs below it. Level-3 readbacks after each refused write show that no register changed.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    typedef enum logic [1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } level_e;

    typedef enum logic {
        SEL_HYP  = 1'b0,
        SEL_KERN = 1'b1
    } name_e;

    typedef enum logic [2:0] {
        OUT_UNDEF,
        OUT_TRAP2,
        OUT_TRAP3,
        OUT_MEM,
        OUT_HYP,
        OUT_KERN
    } outcome_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic [2:0] nv;
        logic       host;
        logic       l2_en;
        logic       l3_present;
        logic       l3_en;
        logic       l2_pm_en;
        logic       fg_impl;
        logic       l3_fg_en;
        logic       fg_rd_ok;
        logic       fg_wr_ok;
        logic       undef_prio;
        logic       undef_sel;
    } cfg_t;

endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
    import pcr_pkg::*;
(
    input  level_e   el,
    input  logic     write,
    input  name_e    sel,
    input  cfg_t     cfg,
    output outcome_e outcome
);

    logic     l3_gate;
    logic     fg_trap;
    outcome_e gate_out;
    outcome_e kern_l1;

    // Level-3 enable gate is closed when level 3 exists and has not opened it.
    assign l3_gate = cfg.l3_present && !cfg.l3_en;

    // Fine-grained trap chooses its permit bit by direction.
    assign fg_trap = cfg.l2_en && cfg.fg_impl &&
                     ((cfg.l3_present && !cfg.l3_fg_en) ||
                      !(write ? cfg.fg_wr_ok : cfg.fg_rd_ok));

    // Outcome of a closed gate once the priority qualifier is clear.
    assign gate_out = cfg.undef_sel ? OUT_UNDEF : OUT_TRAP3;

    always_comb begin
        if (l3_gate && cfg.undef_prio)      kern_l1 = OUT_UNDEF;
        else if (fg_trap)                   kern_l1 = OUT_TRAP2;
        else if (cfg.l2_en && !cfg.l2_pm_en) kern_l1 = OUT_TRAP2;
        else if (l3_gate)                   kern_l1 = gate_out;
        else if (cfg.nv == 3'b111)          kern_l1 = OUT_MEM;
        else                                kern_l1 = OUT_KERN;
    end

    always_comb begin
        outcome = OUT_UNDEF;
        unique case (el)
            LVL0: outcome = OUT_UNDEF;
            LVL1: begin
                if (sel == SEL_HYP) outcome = cfg.nv[0] ? OUT_TRAP2 : OUT_UNDEF;
                else                outcome = kern_l1;
            end
            LVL2: begin
                if (l3_gate)              outcome = cfg.undef_prio ? OUT_UNDEF : gate_out;
                else if (sel == SEL_HYP)  outcome = OUT_HYP;
                else if (cfg.host)        outcome = OUT_HYP;
                else                      outcome = OUT_KERN;
            end
            LVL3: outcome = (sel == SEL_HYP) ? OUT_HYP : OUT_KERN;
        endcase
    end

endmodule

// File: rtl/pcr_regbank.sv
module pcr_regbank #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_kern,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] hyp_q,
    output logic [DATA_W-1:0] kern_q
);

    localparam int NBANK = 2;

    logic [DATA_W-1:0] bank_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = wr_en && (wr_kern == (b == 1));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   bank_q[b] <= '0;
            else if (hit) bank_q[b] <= wdata;
        end
    end

    assign hyp_q  = bank_q[0];
    assign kern_q = bank_q[1];

endmodule

// File: rtl/pcr_access_arbiter.sv
module pcr_access_arbiter
    import pcr_pkg::*;
#(
    parameter int              DATA_W  = 64,
    parameter int              OFS_W   = 12,
    parameter logic [OFS_W-1:0] MEM_OFS = 12'h8E8,
    parameter int              EC_W    = 6,
    parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_el,
    input  logic              req_write,
    input  logic              req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [2:0]        cfg_nv,
    input  logic              cfg_host,
    input  logic              cfg_l2_en,
    input  logic              cfg_l3_present,
    input  logic              cfg_l3_en,
    input  logic              cfg_l2_pm_en,
    input  logic              cfg_fg_impl,
    input  logic              cfg_l3_fg_en,
    input  logic              cfg_fg_rd_ok,
    input  logic              cfg_fg_wr_ok,
    input  logic              cfg_undef_prio,
    input  logic              cfg_undef_sel,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_undef,
    output logic              rsp_trap_l2,
    output logic              rsp_trap_l3,
    output logic [EC_W-1:0]   rsp_syn_class,
    output logic              rsp_mem_redir,
    output logic              rsp_mem_wr,
    output logic [OFS_W-1:0]  rsp_mem_ofs,
    output logic [DATA_W-1:0] rsp_mem_wdata
);

    state_e            state_q, state_d;
    cfg_t              cfg;
    outcome_e          outcome;
    logic [DATA_W-1:0] hyp_q, kern_q;
    logic [DATA_W-1:0] rd_mux;
    logic              reg_wr;

    assign cfg = '{nv: cfg_nv, host: cfg_host, l2_en: cfg_l2_en,
                   l3_present: cfg_l3_present, l3_en: cfg_l3_en,
                   l2_pm_en: cfg_l2_pm_en, fg_impl: cfg_fg_impl,
                   l3_fg_en: cfg_l3_fg_en, fg_rd_ok: cfg_fg_rd_ok,
                   fg_wr_ok: cfg_fg_wr_ok, undef_prio: cfg_undef_prio,
                   undef_sel: cfg_undef_sel};

    pcr_decode u_decode (
        .el      (level_e'(req_el)),
        .write   (req_write),
        .sel     (name_e'(req_sel)),
        .cfg     (cfg),
        .outcome (outcome)
    );

    assign reg_wr = req_valid && req_write &&
                    (outcome == OUT_HYP || outcome == OUT_KERN);

    pcr_regbank #(.DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_kern (outcome == OUT_KERN),
        .wdata   (req_wdata),
        .hyp_q   (hyp_q),
        .kern_q  (kern_q)
    );

    assign rd_mux = (outcome == OUT_KERN) ? kern_q : hyp_q;

    // Next-state logic: accept / chain on a strobe, retire / wait otherwise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign rsp_valid = (state_q == ST_RESP);

    // Output registers, loaded with the outcome of each accepted strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata     <= '0;
            rsp_undef     <= 1'b0;
            rsp_trap_l2   <= 1'b0;
            rsp_trap_l3   <= 1'b0;
            rsp_syn_class <= '0;
            rsp_mem_redir <= 1'b0;
            rsp_mem_wr    <= 1'b0;
            rsp_mem_ofs   <= '0;
            rsp_mem_wdata <= '0;
        end else if (state_d == ST_RESP) begin
            rsp_undef     <= (outcome == OUT_UNDEF);
            rsp_trap_l2   <= (outcome == OUT_TRAP2);
            rsp_trap_l3   <= (outcome == OUT_TRAP3);
            rsp_syn_class <= (outcome == OUT_TRAP2 || outcome == OUT_TRAP3) ? TRAP_EC : '0;
            rsp_mem_redir <= (outcome == OUT_MEM);
            rsp_mem_wr    <= (outcome == OUT_MEM) && req_write;
            rsp_mem_ofs   <= (outcome == OUT_MEM) ? MEM_OFS : '0;
            rsp_mem_wdata <= (outcome == OUT_MEM && req_write) ? req_wdata : '0;
            rsp_rdata     <= (!req_write && (outcome == OUT_HYP || outcome == OUT_KERN))
                             ? rd_mux : '0;
        end else begin
            rsp_rdata     <= '0;
            rsp_undef     <= 1'b0;
            rsp_trap_l2   <= 1'b0;
            rsp_trap_l3   <= 1'b0;
            rsp_syn_class <= '0;
            rsp_mem_redir <= 1'b0;
            rsp_mem_wr    <= 1'b0;
            rsp_mem_ofs   <= '0;
            rsp_mem_wdata <= '0;
        end
    end

endmodule

// File: rtl/pcr_chk.sv
module pcr_chk #(
    parameter int DATA_W = 64,
    parameter int EC_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_el,
    input logic              rsp_valid,
    input logic              rsp_undef,
    input logic              rsp_trap_l2,
    input logic              rsp_trap_l3,
    input logic              rsp_mem_redir,
    input logic [EC_W-1:0]   rsp_syn_class,
    input logic [DATA_W-1:0] hyp_q,
    input logic [DATA_W-1:0] kern_q
);

    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R11
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_undef, rsp_trap_l2, rsp_trap_l3, rsp_mem_redir}));

    // R5
    trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap_l2 || rsp_trap_l3) |-> rsp_syn_class == 6'h18);

    // R2
    lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_el == 2'd0) |=> rsp_undef);

    // R10
    lvl3_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_el == 2'd3) |=>
        !(rsp_undef || rsp_trap_l2 || rsp_trap_l3 || rsp_mem_redir));

    // R12
    refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_undef || rsp_trap_l2 || rsp_trap_l3 || rsp_mem_redir))
        |-> ($stable(hyp_q) && $stable(kern_q)));

endmodule

bind pcr_access_arbiter pcr_chk #(.DATA_W(DATA_W), .EC_W(EC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_el        (req_el),
    .rsp_valid     (rsp_valid),
    .rsp_undef     (rsp_undef),
    .rsp_trap_l2   (rsp_trap_l2),
    .rsp_trap_l3   (rsp_trap_l3),
    .rsp_mem_redir (rsp_mem_redir),
    .rsp_syn_class (rsp_syn_class),
    .hyp_q         (hyp_q),
    .kern_q        (kern_q)
);

// File: tb/sim_pcr_access_arbiter.sv
module sim_pcr_access_arbiter;

    localparam int K_UNDEF = 0;
    localparam int K_T2    = 1;
    localparam int K_T3    = 2;
    localparam int K_MEM   = 3;
    localparam int K_DATA  = 4;

    localparam logic [63:0] VA = 64'hA5A5_0000_1111_2222;
    localparam logic [63:0] VB = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] VC = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] VD = 64'h5A5A_F00F_0FF0_C33C;
    localparam logic [63:0] VE = 64'h1111_2222_3333_4444;

    typedef struct {
        int          kind;
        logic [63:0] data;
        logic        wr;
        logic [63:0] wdata;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_el = '0;
    logic        req_write = 1'b0;
    logic        req_sel = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [2:0]  cfg_nv = '0;
    logic        cfg_host = 1'b0;
    logic        cfg_l2_en = 1'b1;
    logic        cfg_l3_present = 1'b1;
    logic        cfg_l3_en = 1'b1;
    logic        cfg_l2_pm_en = 1'b1;
    logic        cfg_fg_impl = 1'b1;
    logic        cfg_l3_fg_en = 1'b1;
    logic        cfg_fg_rd_ok = 1'b1;
    logic        cfg_fg_wr_ok = 1'b1;
    logic        cfg_undef_prio = 1'b0;
    logic        cfg_undef_sel = 1'b0;

    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_undef, rsp_trap_l2, rsp_trap_l3;
    logic [5:0]  rsp_syn_class;
    logic        rsp_mem_redir, rsp_mem_wr;
    logic [11:0] rsp_mem_ofs;
    logic [63:0] rsp_mem_wdata;

    int   checks = 0;
    int   failures = 0;
    int   issued = 0;
    int   seen = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    pcr_access_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_el(req_el),
        .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
        .cfg_nv(cfg_nv), .cfg_host(cfg_host), .cfg_l2_en(cfg_l2_en),
        .cfg_l3_present(cfg_l3_present), .cfg_l3_en(cfg_l3_en),
        .cfg_l2_pm_en(cfg_l2_pm_en), .cfg_fg_impl(cfg_fg_impl),
        .cfg_l3_fg_en(cfg_l3_fg_en), .cfg_fg_rd_ok(cfg_fg_rd_ok),
        .cfg_fg_wr_ok(cfg_fg_wr_ok), .cfg_undef_prio(cfg_undef_prio),
        .cfg_undef_sel(cfg_undef_sel), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef), .rsp_trap_l2(rsp_trap_l2),
        .rsp_trap_l3(rsp_trap_l3), .rsp_syn_class(rsp_syn_class),
        .rsp_mem_redir(rsp_mem_redir), .rsp_mem_wr(rsp_mem_wr),
        .rsp_mem_ofs(rsp_mem_ofs), .rsp_mem_wdata(rsp_mem_wdata)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // Driver: one strobe, expected result pushed to the scoreboard.
    task automatic access(input logic [1:0] el, input logic wr, input logic sel,
                          input logic [63:0] wd, input int kind,
                          input logic [63:0] data, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_el = el; req_write = wr; req_sel = sel; req_wdata = wd;
        e.kind = kind; e.data = data; e.wr = wr; e.wdata = wd; e.tag = tag;
        sb.push_back(e);
        issued++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            logic [5:0] syn;
            seen++;
            if (sb.size() == 0) begin
                check(1'b0, "R11", "unexpected response", 64'd1, 64'd0);
            end else begin
                e = sb.pop_front();
                syn = (e.kind == K_T2 || e.kind == K_T3) ? 6'h18 : 6'h00;
                check({rsp_undef, rsp_trap_l2, rsp_trap_l3, rsp_mem_redir} ==
                      {e.kind == K_UNDEF, e.kind == K_T2, e.kind == K_T3, e.kind == K_MEM},
                      e.tag, "outcome{undef,t2,t3,mem}",
                      {60'd0, rsp_undef, rsp_trap_l2, rsp_trap_l3, rsp_mem_redir},
                      {60'd0, e.kind == K_UNDEF, e.kind == K_T2, e.kind == K_T3, e.kind == K_MEM});
                check(rsp_syn_class == syn, e.tag, "syndrome", {58'd0, rsp_syn_class}, {58'd0, syn});
                check(rsp_rdata == e.data, e.tag, "rdata", rsp_rdata, e.data);
                if (e.kind == K_MEM) begin
                    check(rsp_mem_ofs == 12'h8E8 && rsp_mem_wr == e.wr &&
                          rsp_mem_wdata == (e.wr ? e.wdata : 64'd0),
                          e.tag, "redirect ofs/wr/wdata", rsp_mem_wdata,
                          e.wr ? e.wdata : 64'd0);
                end
            end
        end
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        access(2'd3, 0, 0, 0, K_DATA, 64'd0, "R1");
        access(2'd3, 0, 1, 0, K_DATA, 64'd0, "R1");

        // R10 level 3 direct access, even with the gate closed
        access(2'd3, 1, 0, VA, K_DATA, 0, "R10");
        access(2'd3, 1, 1, VB, K_DATA, 0, "R10");
        cfg_l3_en = 0; cfg_undef_prio = 1;
        access(2'd3, 0, 0, 0, K_DATA, VA, "R10");
        access(2'd3, 0, 1, 0, K_DATA, VB, "R10");
        cfg_l3_en = 1; cfg_undef_prio = 0;

        // R2 level 0
        access(2'd0, 0, 0, 0, K_UNDEF, 0, "R2");
        access(2'd0, 1, 1, VE, K_UNDEF, 0, "R2");

        // R3 level 1 hypervisor name
        cfg_nv = 3'b001;
        access(2'd1, 0, 0, 0, K_T2, 0, "R3");
        access(2'd1, 1, 0, VE, K_T2, 0, "R3");
        cfg_nv = 3'b110;
        access(2'd1, 0, 0, 0, K_UNDEF, 0, "R3");
        cfg_nv = 3'b000;
        access(2'd1, 1, 0, VE, K_UNDEF, 0, "R3");
        // R12 refused writes left registers intact
        access(2'd3, 0, 0, 0, K_DATA, VA, "R12");
        access(2'd3, 0, 1, 0, K_DATA, VB, "R12");

        // R4 level 2 gate
        cfg_l3_en = 0; cfg_undef_prio = 1;
        access(2'd2, 0, 0, 0, K_UNDEF, 0, "R4");
        cfg_undef_prio = 0; cfg_undef_sel = 1;
        access(2'd2, 1, 1, VE, K_UNDEF, 0, "R4");
        cfg_undef_sel = 0;
        access(2'd2, 0, 0, 0, K_T3, 0, "R4");
        access(2'd2, 1, 0, VE, K_T3, 0, "R5");
        cfg_l3_present = 0;
        access(2'd2, 0, 0, 0, K_DATA, VA, "R4");
        cfg_l3_present = 1; cfg_l3_en = 1;
        access(2'd2, 0, 1, 0, K_DATA, VB, "R4");

        // R9 host-mode aliasing at level 2
        cfg_host = 1;
        access(2'd2, 0, 1, 0, K_DATA, VA, "R9");
        access(2'd2, 1, 1, VC, K_DATA, 0, "R9");
        access(2'd3, 0, 0, 0, K_DATA, VC, "R9");
        access(2'd3, 0, 1, 0, K_DATA, VB, "R9");
        cfg_host = 0;
        access(2'd2, 0, 1, 0, K_DATA, VB, "R9");

        // R6 level 1 kernel-name priority chain
        cfg_l3_en = 0; cfg_undef_prio = 1; cfg_fg_rd_ok = 0; cfg_l2_pm_en = 0;
        access(2'd1, 0, 1, 0, K_UNDEF, 0, "R6");
        cfg_undef_prio = 0;
        access(2'd1, 0, 1, 0, K_T2, 0, "R6");
        cfg_fg_rd_ok = 1;
        access(2'd1, 0, 1, 0, K_T2, 0, "R6");
        cfg_l2_pm_en = 1;
        access(2'd1, 0, 1, 0, K_T3, 0, "R6");
        cfg_undef_sel = 1;
        access(2'd1, 0, 1, 0, K_UNDEF, 0, "R6");
        cfg_undef_sel = 0; cfg_l2_pm_en = 0; cfg_l2_en = 0;
        access(2'd1, 0, 1, 0, K_T3, 0, "R6");
        cfg_l3_en = 1; cfg_l2_pm_en = 1; cfg_l2_en = 1;
        access(2'd1, 0, 1, 0, K_DATA, VB, "R6");

        // R7 fine-grained trap, direction-selected permit
        cfg_fg_rd_ok = 0;
        access(2'd1, 0, 1, 0, K_T2, 0, "R7");
        access(2'd1, 1, 1, VD, K_DATA, 0, "R7");
        cfg_fg_rd_ok = 1; cfg_fg_wr_ok = 0;
        access(2'd1, 0, 1, 0, K_DATA, VD, "R7");
        access(2'd1, 1, 1, VE, K_T2, 0, "R7");
        cfg_fg_wr_ok = 1; cfg_l3_fg_en = 0;
        access(2'd1, 0, 1, 0, K_T2, 0, "R7");
        cfg_l3_present = 0;
        access(2'd1, 0, 1, 0, K_DATA, VD, "R7");
        cfg_l3_present = 1; cfg_l3_fg_en = 1; cfg_fg_rd_ok = 0; cfg_fg_impl = 0;
        access(2'd1, 0, 1, 0, K_DATA, VD, "R7");
        cfg_fg_rd_ok = 1; cfg_fg_impl = 1;

        // R8 memory redirect
        cfg_nv = 3'b111;
        access(2'd1, 0, 1, 0, K_MEM, 0, "R8");
        access(2'd1, 1, 1, VE, K_MEM, 0, "R8");
        cfg_l2_pm_en = 0;
        access(2'd1, 0, 1, 0, K_T2, 0, "R8");
        cfg_l2_pm_en = 1; cfg_nv = 3'b000;
        access(2'd3, 0, 1, 0, K_DATA, VD, "R12");
        access(2'd3, 0, 0, 0, K_DATA, VC, "R12");

        repeat (4) @(negedge clk);
        // R11 one response per strobe
        check(seen == issued && sb.size() == 0, "R11", "response count",
              seen, issued);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule